// File: doc/BRIEF.md
# 8-bit Accumulator ALU with Flag Register

This block is the arithmetic and logic datapath of an 8-bit accumulator processor. In one combinational pass it takes an operation code, the accumulator, a second operand and the current flag byte. It returns the result byte, a write strobe for that result and the complete next flag byte. The incoming flag byte does two jobs: it supplies the carry-in for the with-carry operations, and it supplies the carry bit that increment and decrement keep unchanged.

The block has no storage and no state register. It has a single evaluation path, which steers one of two engines into a flag packer. The first engine is a shared adder/subtractor that handles add, add-with-carry, subtract, subtract-with-borrow, compare, increment, decrement and negate. The second is a bitwise unit that handles AND, XOR and OR. Both undocumented flag copies are produced. The parity and overflow indications share one flag bit.

Top module: `alu8_core`

## Requirements
- R1: The 4-bit operation code selects: 0 ADD, 1 ADC, 2 SUB, 3 SBC, 4 CP, 5 AND, 6 XOR, 7 OR, 8 INC, 9 DEC, 10 NEG. Every coded operation except CP raises the result write strobe, and the result is the 8-bit outcome of the operation. INC, DEC and NEG act on the accumulator.
- R2: Flag byte layout: bit 7 sign, bit 6 zero, bit 5 copy Y, bit 4 half-carry, bit 3 copy X, bit 2 parity/overflow, bit 1 subtract, bit 0 carry. For add-type operations, carry is the carry out of bit 7. For subtract-type operations, it is the borrow out of bit 7.
- R3: Half-carry is the carry (or borrow) out of the low nibble, and it includes any carry-in.
- R4: For arithmetic, parity/overflow reports two's-complement overflow of the signed result.
- R5: Sign equals result bit 7. Zero is set exactly when the 8-bit result is 0x00.
- R6: Copy Y and copy X take result bits 5 and 3. For CP they take bits 5 and 3 of the second operand instead.
- R7: CP produces the same sign, zero, half-carry, overflow, subtract and carry flags as SUB on the same inputs, and it does not raise the write strobe.
- R8: AND, XOR and OR clear subtract and carry. Parity/overflow is set when the result has an even number of one bits. Half-carry is set for AND only.
- R9: INC and DEC add or subtract 1 and return flag bit 0 exactly as it came in. Subtract is 0 for INC and 1 for DEC.
- R10: NEG returns 0 minus the accumulator and sets flags by the subtract rules, with subtract set.
- R11: ADC and SBC include incoming flag bit 0 as carry-in or borrow-in. ADD, SUB and CP ignore it.
- R12: Operation codes 11 to 15 lower the write strobe and return the incoming flag byte unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_i | input | 4 | Operation code (R1 encoding) |
| acc_i | input | 8 | Accumulator value, the left operand |
| opnd_i | input | 8 | Second operand |
| flags_i | input | 8 | Current flag byte |
| result_o | output | 8 | Result byte |
| result_we_o | output | 1 | Result write strobe |
| flags_o | output | 8 | Next flag byte |

## Verification
The hardest conditions to reach are the ones where the carry-in alone decides the outcome. Examples are ADC of 0xFF with carry set, where the half-carry and carry come only from the injected bit, and SBC where the borrow-in turns a zero difference into 0xFF. A plain sweep seldom lands on these. The bench therefore drives them directly with flags_i bit 0 forced to both values. It also runs a strided sweep of every operation against an integer model that works out overflow from signed ranges rather than from sign bits.

// File: rtl/alu8_pkg.sv
package alu8_pkg;
    localparam int DATA_W = 8;
    localparam int OP_W   = 4;

    localparam logic [OP_W-1:0] OP_ADD = 4'd0;
    localparam logic [OP_W-1:0] OP_ADC = 4'd1;
    localparam logic [OP_W-1:0] OP_SUB = 4'd2;
    localparam logic [OP_W-1:0] OP_SBC = 4'd3;
    localparam logic [OP_W-1:0] OP_CP  = 4'd4;
    localparam logic [OP_W-1:0] OP_AND = 4'd5;
    localparam logic [OP_W-1:0] OP_XOR = 4'd6;
    localparam logic [OP_W-1:0] OP_OR  = 4'd7;
    localparam logic [OP_W-1:0] OP_INC = 4'd8;
    localparam logic [OP_W-1:0] OP_DEC = 4'd9;
    localparam logic [OP_W-1:0] OP_NEG = 4'd10;

    // flag bit positions
    localparam int FB_S  = 7;
    localparam int FB_Z  = 6;
    localparam int FB_Y  = 5;
    localparam int FB_H  = 4;
    localparam int FB_X  = 3;
    localparam int FB_PV = 2;
    localparam int FB_N  = 1;
    localparam int FB_C  = 0;

    typedef enum logic [1:0] {
        BW_AND = 2'd0,
        BW_XOR = 2'd1,
        BW_OR  = 2'd2
    } bw_sel_t;

    typedef enum logic [1:0] {
        PATH_ARITH = 2'd0,
        PATH_LOGIC = 2'd1,
        PATH_IDLE  = 2'd2
    } path_t;
endpackage

// File: rtl/alu8_addsub.sv
module alu8_addsub #(
    parameter int DW = 8
) (
    input  logic [DW-1:0] x_i,
    input  logic [DW-1:0] y_i,
    input  logic          cin_i,
    input  logic          sub_i,
    output logic [DW-1:0] sum_o,
    output logic          cout_o,
    output logic          hout_o,
    output logic          ovf_o
);
    localparam int HB  = 4;
    localparam int MSB = DW - 1;

    logic [DW:0] wide;
    logic [HB:0] low;

    always_comb begin
        if (sub_i) begin
            wide = {1'b0, x_i} - {1'b0, y_i} - (DW+1)'(cin_i);
            low  = {1'b0, x_i[HB-1:0]} - {1'b0, y_i[HB-1:0]} - (HB+1)'(cin_i);
        end else begin
            wide = {1'b0, x_i} + {1'b0, y_i} + (DW+1)'(cin_i);
            low  = {1'b0, x_i[HB-1:0]} + {1'b0, y_i[HB-1:0]} + (HB+1)'(cin_i);
        end
        sum_o  = wide[DW-1:0];
        cout_o = wide[DW];
        hout_o = low[HB];
        if (sub_i)
            ovf_o = (x_i[MSB] != y_i[MSB]) && (wide[MSB] != x_i[MSB]);
        else
            ovf_o = (x_i[MSB] == y_i[MSB]) && (wide[MSB] != x_i[MSB]);
    end
endmodule

// File: rtl/alu8_bitwise.sv
module alu8_bitwise
    import alu8_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic [DW-1:0] a_i,
    input  logic [DW-1:0] b_i,
    input  bw_sel_t       sel_i,
    output logic [DW-1:0] r_o,
    output logic          even_o
);
    always_comb begin
        unique case (sel_i)
            BW_AND:  r_o = a_i & b_i;
            BW_XOR:  r_o = a_i ^ b_i;
            BW_OR:   r_o = a_i | b_i;
            default: r_o = '0;
        endcase
        even_o = ~(^r_o);
    end
endmodule

// File: rtl/alu8_core.sv
module alu8_core
    import alu8_pkg::*;
(
    input  logic [3:0] op_i,
    input  logic [7:0] acc_i,
    input  logic [7:0] opnd_i,
    input  logic [7:0] flags_i,
    output logic [7:0] result_o,
    output logic       result_we_o,
    output logic [7:0] flags_o
);
    logic [DATA_W-1:0] ax, ay, asum, lres;
    logic              acin, asub, acout, ahout, aovf, leven;
    logic              keep_c, copy_opnd;
    bw_sel_t           bsel;
    path_t             path;

    // operand steering and path selection
    always_comb begin
        ax        = acc_i;
        ay        = opnd_i;
        acin      = 1'b0;
        asub      = 1'b0;
        keep_c    = 1'b0;
        copy_opnd = 1'b0;
        bsel      = BW_AND;
        path      = PATH_ARITH;
        unique case (op_i)
            OP_ADD: ;
            OP_ADC: acin = flags_i[FB_C];
            OP_SUB: asub = 1'b1;
            OP_SBC: begin asub = 1'b1; acin = flags_i[FB_C]; end
            OP_CP:  begin asub = 1'b1; copy_opnd = 1'b1; end
            OP_INC: begin ay = DATA_W'(1); keep_c = 1'b1; end
            OP_DEC: begin ay = DATA_W'(1); asub = 1'b1; keep_c = 1'b1; end
            OP_NEG: begin ax = '0; ay = acc_i; asub = 1'b1; end
            OP_AND: begin path = PATH_LOGIC; bsel = BW_AND; end
            OP_XOR: begin path = PATH_LOGIC; bsel = BW_XOR; end
            OP_OR:  begin path = PATH_LOGIC; bsel = BW_OR;  end
            default: path = PATH_IDLE;
        endcase
    end

    alu8_addsub #(.DW(DATA_W)) u_addsub (
        .x_i   (ax),
        .y_i   (ay),
        .cin_i (acin),
        .sub_i (asub),
        .sum_o (asum),
        .cout_o(acout),
        .hout_o(ahout),
        .ovf_o (aovf)
    );

    alu8_bitwise #(.DW(DATA_W)) u_bitwise (
        .a_i   (acc_i),
        .b_i   (opnd_i),
        .sel_i (bsel),
        .r_o   (lres),
        .even_o(leven)
    );

    // flag packing
    always_comb begin
        logic [DATA_W-1:0] src;
        result_o    = '0;
        result_we_o = 1'b0;
        flags_o     = flags_i;
        unique case (path)
            PATH_ARITH: begin
                result_o    = asum;
                result_we_o = ~copy_opnd;
                src         = copy_opnd ? opnd_i : asum;
                flags_o[FB_S]  = asum[DATA_W-1];
                flags_o[FB_Z]  = (asum == '0);
                flags_o[FB_Y]  = src[5];
                flags_o[FB_H]  = ahout;
                flags_o[FB_X]  = src[3];
                flags_o[FB_PV] = aovf;
                flags_o[FB_N]  = asub;
                flags_o[FB_C]  = keep_c ? flags_i[FB_C] : acout;
            end
            PATH_LOGIC: begin
                result_o    = lres;
                result_we_o = 1'b1;
                flags_o[FB_S]  = lres[DATA_W-1];
                flags_o[FB_Z]  = (lres == '0);
                flags_o[FB_Y]  = lres[5];
                flags_o[FB_H]  = (bsel == BW_AND);
                flags_o[FB_X]  = lres[3];
                flags_o[FB_PV] = leven;
                flags_o[FB_N]  = 1'b0;
                flags_o[FB_C]  = 1'b0;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/alu8_core_chk.sv
module alu8_core_chk
    import alu8_pkg::*;
(
    input logic [3:0] op_i,
    input logic [7:0] acc_i,
    input logic [7:0] opnd_i,
    input logic [7:0] flags_i,
    input logic [7:0] result_o,
    input logic       result_we_o,
    input logic [7:0] flags_o
);
    always_comb begin
        if (op_i == OP_CP)
            a_r7_cp_no_write: assert (!result_we_o);
        if (op_i == OP_INC || op_i == OP_DEC)
            a_r9_keep_carry: assert (flags_o[FB_C] == flags_i[FB_C]);
        if (op_i == OP_AND || op_i == OP_XOR || op_i == OP_OR)
            a_r8_logic_flags: assert (flags_o[FB_N] == 1'b0 && flags_o[FB_C] == 1'b0
                                      && flags_o[FB_H] == (op_i == OP_AND));
        if (op_i > OP_NEG)
            a_r12_idle_pass: assert (!result_we_o && flags_o == flags_i);
        if (result_we_o)
            a_r5_sign_zero: assert (flags_o[FB_S] == result_o[7]
                                    && flags_o[FB_Z] == (result_o == 8'h00));
        if (result_we_o)
            a_r6_copy_bits: assert (flags_o[FB_Y] == result_o[5]
                                    && flags_o[FB_X] == result_o[3]);
        if (op_i == OP_CP)
            a_r6_cp_copy: assert (flags_o[FB_Y] == opnd_i[5]
                                  && flags_o[FB_X] == opnd_i[3]);
        if (op_i == OP_NEG)
            a_r10_neg_value: assert (result_o == 8'(0 - acc_i) && flags_o[FB_N]);
    end
endmodule

bind alu8_core alu8_core_chk u_chk (
    .op_i       (op_i),
    .acc_i      (acc_i),
    .opnd_i     (opnd_i),
    .flags_i    (flags_i),
    .result_o   (result_o),
    .result_we_o(result_we_o),
    .flags_o    (flags_o)
);

// File: tb/alu8_core_tb.sv
module alu8_core_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] op;
    logic [7:0] acc, opnd, fin;
    logic [7:0] res, fout;
    logic       we;
    int total = 0;
    int bad   = 0;
    int wd    = 0;

    always #2 clk = ~clk;

    alu8_core u_dut (
        .op_i(op), .acc_i(acc), .opnd_i(opnd), .flags_i(fin),
        .result_o(res), .result_we_o(we), .flags_o(fout)
    );

    // reference model from the requirements: returns {we, result, flags}
    function automatic logic [16:0] model(input int o, input int a, input int b, input logic [7:0] f);
        int x, y, ci, full, lo, sv, r;
        logic sub, c, h, v, w;
        logic [7:0] rr, cpy, nf;
        if (o > 10) return {1'b0, 8'h00, f};
        w = (o != 4);
        if (o >= 5 && o <= 7) begin
            rr = (o == 5) ? 8'(a & b) : (o == 6) ? 8'(a ^ b) : 8'(a | b);
            nf = {rr[7], rr == 0, rr[5], o == 5, rr[3], ($countones(rr) % 2) == 0, 1'b0, 1'b0};
            return {1'b1, rr, nf};
        end
        x = a; y = b; ci = 0; sub = 0;
        case (o)
            1: ci = f[0];
            2: sub = 1;
            3: begin sub = 1; ci = f[0]; end
            4: sub = 1;
            8: y = 1;
            9: begin y = 1; sub = 1; end
            10: begin x = 0; y = a; sub = 1; end
            default: ;
        endcase
        if (sub) begin
            full = x - y - ci; c = full < 0;
            lo = (x % 16) - (y % 16) - ci; h = lo < 0;
            sv = $signed(8'(x)) - $signed(8'(y)) - ci;
        end else begin
            full = x + y + ci; c = full > 255;
            lo = (x % 16) + (y % 16) + ci; h = lo > 15;
            sv = $signed(8'(x)) + $signed(8'(y)) + ci;
        end
        v = (sv > 127) || (sv < -128);
        r = full & 255; rr = 8'(r);
        cpy = (o == 4) ? 8'(b) : rr;
        if (o == 8 || o == 9) c = f[0];
        nf = {rr[7], rr == 0, cpy[5], h, cpy[3], v, sub, c};
        return {w, rr, nf};
    endfunction

    task automatic apply(input int o, input int a, input int b, input logic [7:0] f);
        op = 4'(o); acc = 8'(a); opnd = 8'(b); fin = f;
        #1;
    endtask

    task automatic expect_out(input string req, input logic [16:0] exp);
        total++;
        if ({we, res, fout} !== exp) begin
            bad++;
            $display("FAIL %s op=%0d a=%h b=%h fin=%h : got we=%b res=%h f=%h exp we=%b res=%h f=%h",
                     req, op, acc, opnd, fin, we, res, fout, exp[16], exp[15:8], exp[7:0]);
        end
    endtask

    task automatic t_idle_start();
        apply(15, 8'h12, 8'h34, 8'hA5);
        expect_out("R12 idle at start", {1'b0, 8'h00, 8'hA5});
        apply(11, 8'hFF, 8'hFF, 8'h5A);
        expect_out("R12 code 11", {1'b0, 8'h00, 8'h5A});
    endtask

    task automatic t_add_corners();
        apply(0, 8'h7F, 8'h01, 8'h01);
        expect_out("R4 R11 add overflow", {1'b1, 8'h80, 8'h94});
        apply(0, 8'hFF, 8'h01, 8'h00);
        expect_out("R2 R5 add carry zero", {1'b1, 8'h00, 8'h51});
    endtask

    task automatic t_carry_in();
        apply(1, 8'h00, 8'hFF, 8'h01);
        expect_out("R11 R3 adc ff cin", {1'b1, 8'h00, 8'h51});
        apply(3, 8'h10, 8'h10, 8'h01);
        expect_out("R11 sbc borrow to ff", model(3, 8'h10, 8'h10, 8'h01));
        apply(3, 8'h10, 8'h10, 8'h00);
        expect_out("R11 sbc no borrow", model(3, 8'h10, 8'h10, 8'h00));
    endtask

    task automatic t_sub_cp();
        apply(2, 8'h00, 8'h01, 8'h00);
        expect_out("R2 R3 sub borrow", {1'b1, 8'hFF, 8'hBB});
        apply(4, 8'h10, 8'h28, 8'h00);
        expect_out("R6 R7 cp", {1'b0, 8'hE8, 8'hBB});
        apply(4, 8'h42, 8'h42, 8'h01);
        expect_out("R7 cp equal", model(4, 8'h42, 8'h42, 8'h01));
    endtask

    task automatic t_logic();
        apply(5, 8'hF0, 8'h3C, 8'hFF);
        expect_out("R8 and", {1'b1, 8'h30, 8'h34});
        apply(6, 8'hFF, 8'hFE, 8'hFF);
        expect_out("R8 xor odd parity", {1'b1, 8'h01, 8'h00});
        apply(7, 8'h00, 8'h00, 8'hFF);
        expect_out("R8 or zero", {1'b1, 8'h00, 8'h44});
    endtask

    task automatic t_incdec_neg();
        apply(8, 8'hFF, 8'h00, 8'h01);
        expect_out("R9 inc wrap keep c", {1'b1, 8'h00, 8'h51});
        apply(9, 8'h80, 8'h00, 8'h00);
        expect_out("R9 dec overflow", model(9, 8'h80, 8'h00, 8'h00));
        apply(10, 8'h80, 8'h00, 8'h00);
        expect_out("R10 neg 80", {1'b1, 8'h80, 8'h87});
        apply(10, 8'h00, 8'h00, 8'h01);
        expect_out("R10 neg zero", model(10, 0, 0, 8'h01));
    endtask

    task automatic t_sweep();
        for (int o = 0; o < 16; o++)
            for (int a = 0; a < 256; a++)
                for (int b = 0; b < 256; b += 17)
                    for (int c = 0; c < 2; c++) begin
                        apply(o, a, b, c ? 8'hFF : 8'h00);
                        expect_out("R1 sweep", model(o, a, b, c ? 8'hFF : 8'h00));
                    end
    endtask

    always @(posedge clk) begin
        wd <= wd + 1;
        if (wd > 150000) begin
            bad++; total++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        op = 4'd15; acc = 0; opnd = 0; fin = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_idle_start();
        t_add_corners();
        t_carry_in();
        t_sub_cp();
        t_logic();
        t_incdec_neg();
        t_sweep();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule